// File: doc/BRIEF.md
# Software-Raised Interrupt Status Controller

This block holds a 32-bit interrupt status word and turns it into an interrupt request for a host. Software sets bits by writing a value to the raise register; that value is ORed into the word. Software clears bits by writing a mask to the acknowledge register; every bit that is set in the mask is removed from the word. Internal engines, such as a compute unit or a DMA unit, can also OR their own completion codes into the word through dedicated source ports. Software reads the word back over a simple register bus.

The request leaves the block in one of two forms, chosen by a configuration input. In level mode, which is the mode when the input is low (its reset value on any sane system), the line stays high for as long as any status bit is set. It drops only after the handler acknowledges every set bit. In message mode, the block emits a single-cycle pulse after each raise that carries a nonzero value. The level line then stays low. The status word behaves the same in both modes, so a handler in message mode must still acknowledge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word reads 0x00000000, and both `irq_level_o` and `irq_msg_o` are low.
- R2: A bus write to offset 0x60 ORs the written value into the status word. The new value is readable from the next cycle.
- R3: A bus write to offset 0x64 clears every status bit that is set in the written value. All other bits are left unchanged.
- R4: If a raise and a clear act on the same bit in the same cycle, the bit ends up set.
- R5: Each internal source whose valid bit `src_vld_i[i]` is high ORs its code `src_code_i[i]` into the status word in that cycle. Codes from several sources in one cycle combine by OR.
- R6: With `msg_mode_i` low, `irq_level_o` equals the OR of all status bits, and `irq_msg_o` stays low.
- R7: With `msg_mode_i` high, `irq_msg_o` is high for exactly the one cycle after each cycle in which a nonzero raise value is applied, from software or an internal source. `irq_level_o` is low in this mode.
- R8: While no raise, clear or source input is active, the status word holds its value and no new pulse is produced.
- R9: Reads at offset 0x24 return the status word. Reads at 0x60, 0x64 and any other offset return zero. Bus writes to 0x24 have no effect.
- R10: A raise or clear write of value zero leaves the status word unchanged and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 8 | Byte offset for both reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| src_vld_i | input | N_SRC | Raise strobe for each internal source |
| src_code_i | input | N_SRC x 32 | Code that each internal source ORs into the status word |
| msg_mode_i | input | 1 | 0: level output, 1: single-cycle message pulse |
| irq_level_o | output | 1 | Level interrupt request |
| irq_msg_o | output | 1 | Message interrupt pulse |

## Verification
The hardest case to reach is an acknowledge and a raise that hit the same bit in the same cycle. The bus carries only one write per cycle, so software cannot create this case alone. The bench drives an acknowledge write on the bus and, in that same cycle, a source strobe whose code overlaps the acknowledge mask. It then reads the word back. In message mode, the bench also checks that the pulse clears one cycle after it rises, and that no new pulse appears while a nonzero word is only held.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_ADDR_W = 8;
  localparam int unsigned IRQ_W      = 32;

  localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 8'h24;
  localparam logic [REG_ADDR_W-1:0] OFS_RAISE  = 8'h60;
  localparam logic [REG_ADDR_W-1:0] OFS_ACK    = 8'h64;

  typedef enum logic {
    OUT_LEVEL = 1'b0,
    OUT_MSG   = 1'b1
  } irq_out_mode_e;
endpackage

// File: rtl/irq_raise_merge.sv
module irq_raise_merge #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = 2
) (
  input  logic                          sw_raise_i,
  input  logic [DATA_W-1:0]             sw_data_i,
  input  logic [N_SRC-1:0]              src_vld_i,
  input  logic [N_SRC-1:0][DATA_W-1:0]  src_code_i,
  output logic [DATA_W-1:0]             raise_o
);
  always_comb begin
    raise_o = sw_raise_i ? sw_data_i : '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_vld_i[i]) raise_o = raise_o | src_code_i[i];
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] raise_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] status_q;

  // clear first, then raise: raise wins on overlapping bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | raise_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_mode_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] raise_i,
  output logic              level_o,
  output logic              msg_o
);
  import irq_pkg::*;

  irq_out_mode_e mode;
  logic          msg_q;

  assign mode = irq_out_mode_e'(msg_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msg_q <= 1'b0;
    else         msg_q <= (mode == OUT_MSG) && (|raise_i);
  end

  assign level_o = (mode == OUT_LEVEL) && (|status_i);
  assign msg_o   = msg_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned N_SRC = 2
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        bus_wr_i,
  input  logic [irq_pkg::REG_ADDR_W-1:0]              bus_addr_i,
  input  logic [irq_pkg::IRQ_W-1:0]                   bus_wdata_i,
  output logic [irq_pkg::IRQ_W-1:0]                   bus_rdata_o,
  input  logic [N_SRC-1:0]                            src_vld_i,
  input  logic [N_SRC-1:0][irq_pkg::IRQ_W-1:0]        src_code_i,
  input  logic                                        msg_mode_i,
  output logic                                        irq_level_o,
  output logic                                        irq_msg_o
);
  import irq_pkg::*;

  localparam int unsigned DW = IRQ_W;

  logic          wr_raise;
  logic          wr_ack;
  logic [DW-1:0] raise_vec;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] status_q;

  assign wr_raise = bus_wr_i && (bus_addr_i == OFS_RAISE);
  assign wr_ack   = bus_wr_i && (bus_addr_i == OFS_ACK);
  assign clr_vec  = wr_ack ? bus_wdata_i : '0;

  irq_raise_merge #(.DATA_W(DW), .N_SRC(N_SRC)) u_merge (
    .sw_raise_i (wr_raise),
    .sw_data_i  (bus_wdata_i),
    .src_vld_i  (src_vld_i),
    .src_code_i (src_code_i),
    .raise_o    (raise_vec)
  );

  irq_status_reg #(.DATA_W(DW)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raise_i  (raise_vec),
    .clr_i    (clr_vec),
    .status_o (status_q)
  );

  irq_out_gen #(.DATA_W(DW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msg_mode_i (msg_mode_i),
    .status_i   (status_q),
    .raise_i    (raise_vec),
    .level_o    (irq_level_o),
    .msg_o      (irq_msg_o)
  );

  // write-only and unmapped offsets read as zero
  assign bus_rdata_o = (bus_addr_i == OFS_STATUS) ? status_q : '0;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned N_SRC = 2
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               bus_wr_i,
  input logic [irq_pkg::REG_ADDR_W-1:0]     bus_addr_i,
  input logic [irq_pkg::IRQ_W-1:0]          bus_wdata_i,
  input logic [irq_pkg::IRQ_W-1:0]          bus_rdata_o,
  input logic [N_SRC-1:0]                   src_vld_i,
  input logic                               msg_mode_i,
  input logic                               irq_level_o,
  input logic                               irq_msg_o,
  input logic [irq_pkg::IRQ_W-1:0]          status_q,
  input logic [irq_pkg::IRQ_W-1:0]          raise_vec
);
  import irq_pkg::*;

  a_r2_raise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_RAISE) |=>
      ((status_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_ACK && src_vld_i == '0) |=>
      ((status_q & $past(bus_wdata_i)) == '0));

  a_r6_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_mode_i |-> (irq_level_o == (status_q != '0)));

  a_r7_no_level_in_msg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_mode_i |-> !irq_level_o);

  a_r7_pulse_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_msg_o |-> ($past(raise_vec) != '0));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_i && src_vld_i == '0) |=> $stable(status_q));

  a_r9_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFS_RAISE || bus_addr_i == OFS_ACK) |-> (bus_rdata_o == '0));
endmodule

bind irq_status_ctrl irq_status_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .src_vld_i   (src_vld_i),
  .msg_mode_i  (msg_mode_i),
  .irq_level_o (irq_level_o),
  .irq_msg_o   (irq_msg_o),
  .status_q    (status_q),
  .raise_vec   (raise_vec)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  localparam int unsigned N_SRC = 2;
  localparam int unsigned NV    = 8;

  // {offset, write data, expected status afterwards}
  localparam logic [71:0] VEC [NV] = '{
    {8'h60, 32'h0000_0005, 32'h0000_0005},
    {8'h60, 32'h0000_0100, 32'h0000_0105},
    {8'h64, 32'h0000_0001, 32'h0000_0104},
    {8'h64, 32'h0000_0000, 32'h0000_0104},
    {8'h60, 32'h0000_0000, 32'h0000_0104},
    {8'h24, 32'hFFFF_FFFF, 32'h0000_0104},
    {8'h60, 32'h8000_0000, 32'h8000_0104},
    {8'h64, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  logic                        clk = 1'b0;
  logic                        rst_n = 1'b0;
  logic                        bus_wr = 1'b0;
  logic [7:0]                  bus_addr = 8'h24;
  logic [31:0]                 bus_wdata = '0;
  logic [31:0]                 bus_rdata;
  logic [N_SRC-1:0]            src_vld = '0;
  logic [N_SRC-1:0][31:0]      src_code = '0;
  logic                        msg_mode = 1'b0;
  logic                        irq_level;
  logic                        irq_msg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_status_ctrl #(.N_SRC(N_SRC)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .src_vld_i   (src_vld),
    .src_code_i  (src_code),
    .msg_mode_i  (msg_mode),
    .irq_level_o (irq_level),
    .irq_msg_o   (irq_msg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge; the posedge commits; the caller samples at the next negedge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h24;
  endtask

  task automatic read_at(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 8'h24;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", bus_rdata, 32'h0);
    check("R1 level", {31'b0, irq_level}, 32'h0);
    check("R1 msg", {31'b0, irq_msg}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R9 R10 status, R6 level
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][71:64], VEC[i][63:32]);
      read_at(8'h24, rd);
      check($sformatf("R2/R3/R9/R10 vec %0d status", i), rd, VEC[i][31:0]);
      check($sformatf("R6 vec %0d level", i), {31'b0, irq_level}, {31'b0, (VEC[i][31:0] != 0)});
      check($sformatf("R6 vec %0d msg", i), {31'b0, irq_msg}, 32'h0);
    end

    // R5 two internal sources in one cycle
    @(negedge clk);
    src_vld = 2'b11; src_code[0] = 32'h0000_0001; src_code[1] = 32'h0000_0100;
    @(negedge clk);
    src_vld = '0;
    read_at(8'h24, rd);
    check("R5 sources OR", rd, 32'h0000_0101);

    // R4 source raise overlaps software ack
    bus_write(8'h60, 32'h0000_00F0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h64; bus_wdata = 32'hFFFF_FFFF;
    src_vld = 2'b01; src_code[0] = 32'h0000_0030;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h24; src_vld = '0;
    read_at(8'h24, rd);
    check("R4 raise wins", rd, 32'h0000_0030);

    // R9 write-only and unmapped offsets read zero
    read_at(8'h60, rd); check("R9 read 0x60", rd, 32'h0);
    read_at(8'h64, rd); check("R9 read 0x64", rd, 32'h0);
    read_at(8'h10, rd); check("R9 read 0x10", rd, 32'h0);

    // R7 message mode
    bus_write(8'h64, 32'hFFFF_FFFF);
    msg_mode = 1'b1;
    @(negedge clk);
    bus_write(8'h60, 32'h0000_0002);
    check("R7 pulse high", {31'b0, irq_msg}, 32'h1);
    check("R7 level low", {31'b0, irq_level}, 32'h0);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, irq_msg}, 32'h0);
    // R8 held status, no re-pulse
    repeat (3) @(negedge clk);
    check("R8 no re-pulse", {31'b0, irq_msg}, 32'h0);
    read_at(8'h24, rd);
    check("R8 status held", rd, 32'h0000_0002);
    // R10 zero raise, no pulse
    bus_write(8'h60, 32'h0);
    check("R10 zero raise no pulse", {31'b0, irq_msg}, 32'h0);
    // R7 internal source pulse
    @(negedge clk);
    src_vld = 2'b10; src_code[1] = 32'h0000_0100;
    @(negedge clk);
    src_vld = '0;
    check("R7 source pulse", {31'b0, irq_msg}, 32'h1);
    // R7 ack still required in message mode
    bus_write(8'h64, 32'h0000_0002);
    read_at(8'h24, rd);
    check("R7 ack in msg mode", rd, 32'h0000_0100);
    check("R7 no pulse on ack", {31'b0, irq_msg}, 32'h0);
    // back to level: R6
    msg_mode = 1'b0;
    #1;
    check("R6 level after mode change", {31'b0, irq_level}, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule